// File: doc/BRIEF.md
# Rule 30 Cellular Automaton Offload Engine

A processor-attached engine that evolves a one-dimensional ring of binary cells under rule 30. Software loads a seed line, an iteration count and a per-iteration wait into memory-mapped registers, then sets the start bit. Each step replaces every cell at once with a value looked up from that cell and its two neighbours in the previous line. The two ends of the line are joined, so the first and last cells are neighbours.

The programmable wait stretches each step. System software can then be timed against accelerators of different assumed speeds without changing the hardware. When the last step has been applied, the engine sets a done flag and can raise an interrupt. The final line is then read back through the same registers.

Top module: `rule30_engine`

## Requirements
- R1: After reset every register reads zero: line, iteration count, wait count, interrupt enable, busy and done. The interrupt output is low.
- R2: A step sets new cell i to bit k of the constant 8'b00011110, where k = left*4 + mid*2 + right is taken from cells i-1, i and i+1 of the old line. So 000→0, 001→1, 010→1, 011→1, 100→1, 101→0, 110→0 and 111→0. All cells are computed from the same old line.
- R3: The left neighbour of cell 0 is cell CELLS-1. The right neighbour of cell CELLS-1 is cell 0.
- R4: A start with a nonzero count N sets busy on the next cycle. Busy then stays high for N*(W+1) cycles, where W is the wait value. The line advances exactly N times, after which busy falls and done rises in the same cycle. Busy and done are never high together.
- R5: While busy, the line changes only on the last cycle of each W+1-cycle step.
- R6: A start with a count of zero sets done on the next cycle. Busy is never asserted and the line is unchanged.
- R7: While busy, a start request is ignored, and writes to the line words are ignored.
- R8: The irq output is high exactly when done and interrupt enable are both set. It stays high until software writes a 1 to STATUS bit 1, which clears done.
- R9: Register map by word address. 0 = CTRL: bit 0 is start and always reads 0; bit 1 is interrupt enable. 1 = STATUS: bit 0 is busy; bit 1 is done. 2 = iteration count, bits [15:0]. 3 = wait per step, bits [15:0]. 4+k = line word k, with cell 32k+j at bit j.
- R10: An accepted start with a nonzero count clears done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Completion interrupt |

## Verification
The engine is run from several kinds of seed line, and each one tells a different fault apart.
- A single set cell in mid-line grows the familiar triangle, which exposes a wrong lookup entry.
- Set cells at both ends of the ring separate wrap-around stepping from open-boundary stepping.
- An all-ones line collapses to zeros in one step.
- A mixed pattern run for 99 steps shows any drift between the lookup and the reference.

Zero counts, several wait values and starts issued while busy pin down the step timing, the done flag and the interrupt.

// File: rtl/rule30_engine.sv
module rule30_engine #(
  parameter int CELLS  = 64,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int WORDS = CELLS / 32;
  localparam logic [7:0] RULE = 8'b0001_1110;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ITER = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_WAIT = ADDR_W'(3);

  logic [CELLS-1:0] line, nxt;
  logic             busy, done, ien;
  logic [CNT_W-1:0] iters, wait_len, rem, wcnt;

  wire start_req = reg_wr && reg_addr == A_CTRL && reg_wdata[0];
  wire done_clr  = reg_wr && reg_addr == A_STAT && reg_wdata[1];

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    assign nxt[g] = RULE[{line[(g + CELLS - 1) % CELLS], line[g], line[(g + 1) % CELLS]}];
  end

  assign irq = done & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ien      <= 1'b0;
      iters    <= '0;
      wait_len <= '0;
      rem      <= '0;
      wcnt     <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ien <= reg_wdata[1];
      if (reg_wr && reg_addr == A_ITER) iters <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == A_WAIT) wait_len <= reg_wdata[CNT_W-1:0];
      if (done_clr) done <= 1'b0;
      if (start_req && !busy) begin
        if (iters == '0) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          done <= 1'b0;
          rem  <= iters;
          wcnt <= wait_len;
        end
      end
      if (busy) begin
        if (wcnt != '0) begin
          wcnt <= wcnt - 1'b1;
        end else begin
          line <= nxt;
          wcnt <= wait_len;
          rem  <= rem - 1'b1;
          if (rem == CNT_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end else if (reg_wr) begin
        for (int k = 0; k < WORDS; k++)
          if (reg_addr == ADDR_W'(4 + k)) line[k*32 +: 32] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[1] = ien;
      A_STAT: reg_rdata[1:0] = {done, busy};
      A_ITER: reg_rdata[CNT_W-1:0] = iters;
      A_WAIT: reg_rdata[CNT_W-1:0] = wait_len;
      default:
        for (int k = 0; k < WORDS; k++)
          if (reg_addr == ADDR_W'(4 + k)) reg_rdata = line[k*32 +: 32];
    endcase
  end

  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wcnt != '0) |=> $stable(line));

  // R7
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem > CNT_W'(1)) |=> busy);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr && !start_req) |=> done);

  // R6
  zero_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy && iters == '0) |=> (done && !busy && $stable(line)));
endmodule

// File: tb/rule30_engine_bench.sv
module rule30_engine_bench;
  localparam int CELLS = 64;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  always #4 clk = ~clk;

  rule30_engine u_rule30_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [CELLS-1:0] m_line;
  bit m_busy, m_done, m_ien;
  int m_iters, m_wait, m_rem, m_cnt;

  function automatic logic [CELLS-1:0] step(input logic [CELLS-1:0] s);
    logic [CELLS-1:0] r;
    for (int i = 0; i < CELLS; i++) begin
      int idx;
      idx = s[(i + CELLS - 1) % CELLS] * 4 + s[i] * 2 + s[(i + 1) % CELLS];
      r[i] = (30 >> idx) & 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0: return {30'd0, m_ien, 1'b0};
      1: return {30'd0, m_done, m_busy};
      2: return m_iters;
      3: return m_wait;
      4: return m_line[31:0];
      5: return m_line[63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      1: return "R4";
      4, 5: return "R2";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = '0; m_busy = 0; m_done = 0; m_ien = 0;
      m_iters = 0; m_wait = 0; m_rem = 0; m_cnt = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (reg_wr) begin
        case (int'(reg_addr))
          0: begin
            m_ien = reg_wdata[1];
            if (reg_wdata[0] && !was_busy) begin
              if (m_iters == 0) m_done = 1;
              else begin
                m_busy = 1; m_done = 0; m_rem = m_iters; m_cnt = m_wait;
              end
            end
          end
          1: if (reg_wdata[1]) m_done = 0;
          2: m_iters = reg_wdata[15:0];
          3: m_wait = reg_wdata[15:0];
          4: if (!was_busy) m_line[31:0] = reg_wdata;
          5: if (!was_busy) m_line[63:32] = reg_wdata;
          default: ;
        endcase
      end
      if (was_busy) begin
        if (m_cnt != 0) m_cnt--;
        else begin
          m_line = step(m_line);
          m_cnt = m_wait;
          m_rem--;
          if (m_rem == 0) begin m_busy = 0; m_done = 1; end
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R8", {31'd0, irq}, {31'd0, m_done & m_ien});
      check(tag_of(int'(reg_addr)), reg_rdata, m_read(int'(reg_addr)));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 0; reg_addr = ADDR_W'(1);
  endtask

  task automatic rd_chk(input int a, input string req, input logic [31:0] exp);
    @(posedge clk); #2;
    reg_addr = ADDR_W'(a);
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && m_busy; i++) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic run(input logic [63:0] seed, input int n, input int w, input string req);
    logic [63:0] exp;
    exp = seed;
    for (int i = 0; i < n; i++) exp = step(exp);
    wr(4, seed[31:0]); wr(5, seed[63:32]);
    wr(2, n); wr(3, w);
    wr(0, 32'h3);
    wait_idle();
    rd_chk(4, req, exp[31:0]);
    rd_chk(5, req, exp[63:32]);
    rd_chk(1, req, 32'h2);
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    for (int a = 0; a < 6; a++) rd_chk(a, "R1", 32'd0);
    check("R1", {31'd0, irq}, 32'd0);

    run(64'h0000_0001_0000_0000, 5, 0, "R2");
    check("R8", {31'd0, irq}, 32'd1);
    wr(1, 32'h2);
    rd_chk(1, "R8", 32'h0);
    check("R8", {31'd0, irq}, 32'd0);

    run(64'h8000_0000_0000_0001, 3, 2, "R3");
    run(64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R2");
    run(64'h1234_5678_9ABC_DEF0, 99, 0, "R2");

    // R6 zero count: done next cycle, line untouched
    wr(1, 32'h2);
    wr(4, 32'hA5A5_0F0F);
    wr(2, 0);
    wr(0, 32'h1);
    rd_chk(1, "R6", 32'h2);
    rd_chk(4, "R6", 32'hA5A5_0F0F);

    // R10 start with done already set clears it; R5 line held during wait
    wr(2, 4); wr(3, 7);
    wr(0, 32'h1);
    rd_chk(1, "R10", 32'h1);
    rd_chk(4, "R5", 32'hA5A5_0F0F);
    rd_chk(4, "R5", 32'hA5A5_0F0F);
    // R7 writes while busy ignored
    wr(4, 32'hFFFF_FFFF);
    wr(0, 32'h1);
    rd_chk(1, "R7", 32'h1);
    wait_idle();
    rd_chk(4, "R7", m_read(4));
    rd_chk(5, "R7", m_read(5));
    rd_chk(1, "R4", 32'h2);
    rd_chk(0, "R9", 32'h0);

    repeat (4) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule